// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Device

This block is one output cell of a small programmable logic device. An AND array builds product terms from a bus of external array inputs plus one feedback bit, using both the true and the complemented form of each. Eight of those terms are ORed into a sum. A polarity bit can invert the sum. The result can drive the pin straight away, or it can first be stored in a flip-flop. That flip-flop acts as a D or a T stage, fires on the rising or falling edge of its selected clock, and is cleared by a product term of its own.

A further product term, called the auxiliary term here, serves two purposes. In synchronous mode the register is clocked from the global clock input and the auxiliary term enables the tri-state pin driver. In asynchronous mode the auxiliary term clocks the register and the driver stays enabled. A feedback selector returns either the stored bit or the pad value to the array.

The whole personality is one static configuration vector, captured while reset is asserted. The block runs on a fast sampling clock `clk_i`. The global clock and the auxiliary clock are both treated as signals: an edge is detected by comparing each sample with the one before. A detected edge updates the register at the sampling-clock edge where it is seen.

Top module: `pld_macrocell`

## Requirements
- R1: The configuration is loaded from `cfg_i` on every sampling edge while `rst_ni` is low, and is held unchanged once reset is released. Reset clears the stored bit and the recorded clock-source history to 0.
- R2: The configuration holds ten terms of 2*(NUM_IN+1) mask bits each, term t at bit t*2*(NUM_IN+1). Within a term, bit 2j selects the true form of array input j and bit 2j+1 selects its complement. Array input j is `in_i[j]` for j < NUM_IN, and input NUM_IN is the feedback bit. A term is the AND of every selected literal.
- R3: Terms 0 to 7 are ORed into the sum. A term with no mask bit set evaluates to 0.
- R4: The polarity bit (configuration bit MB = 10*2*(NUM_IN+1)) inverts the sum when it is 1.
- R5: When the output-path bit MB+4 is 0, `pin_o` follows the polarity-adjusted sum combinationally. When it is 1, `pin_o` shows the stored bit, which does not follow the sum between clock edges.
- R6: When clock-mode bit MB+1 is 0, the register clocks on edges of `gclk_i`, and `pin_oe_o` equals the auxiliary term (term 8).
- R7: When clock-mode bit MB+1 is 1, the auxiliary term clocks the register, `gclk_i` has no effect, and `pin_oe_o` is held at 1.
- R8: Edge bit MB+3 picks the active edge: 0 for rising, 1 for falling. The stored bit changes only on an active edge or a clear.
- R9: When type bit MB+2 is 0, the register loads the polarity-adjusted sum at an active edge. When it is 1, the register inverts its value when that sum is 1 and holds when it is 0.
- R10: When the clear term (term 9) is 1, the stored bit becomes 0 at the next sampling edge, whether or not a clock edge occurs, and any clock edge is overridden.
- R11: When feedback bit MB+5 is 0, the feedback bit (`fb_o` and array input NUM_IN) is the stored bit. When it is 1, the feedback bit is `pin_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock for all state |
| rst_ni | input | 1 | Active-low synchronous reset; configuration load window |
| cfg_i | input | (NUM_SUM+2)*2*(NUM_IN+1)+6 | Static personality vector |
| in_i | input | NUM_IN | External array inputs |
| gclk_i | input | 1 | Global register clock, edge-detected |
| pin_i | input | 1 | Pad value read back for feedback |
| pin_o | output | 1 | Value presented to the pin driver |
| pin_oe_o | output | 1 | Tri-state enable of the pin driver |
| fb_o | output | 1 | Feedback bit returned to the array |

## Verification
The bench builds the cell with its defaults: four external inputs and eight summed terms. That makes the configuration vector 106 bits wide, with the mode bits starting at bit 100. With only four external inputs, every one of the sixteen input patterns can be swept in both polarities, so each literal form and the empty-term case are checked exhaustively. The feedback bit is the fifth array input, so the tests can send stored state and pad read-back around the array loop. Each clock scenario is set up with its own configuration load, so captures, toggles, ignored edges and clear overrides are observed at the pin one sampling cycle after the stimulus.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

    localparam int MODE_W = 6;

    // Mode bits, LSB first: polarity, clock mode, type, edge, output path, feedback
    typedef struct packed {
        logic fb_pin;
        logic out_reg;
        logic neg_edge;
        logic toggle;
        logic async_clk;
        logic invert;
    } mc_mode_t;

endpackage

// File: rtl/mc_and_array.sv
`timescale 1ns/1ps
module mc_and_array #(
    parameter int ARR_W     = 5,
    parameter int NUM_TERMS = 10,
    localparam int TERM_W   = 2 * ARR_W,
    localparam int MASK_W   = NUM_TERMS * TERM_W
) (
    input  logic [MASK_W-1:0]    mask_i,
    input  logic [ARR_W-1:0]     lit_i,
    output logic [NUM_TERMS-1:0] term_o
);

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        logic [TERM_W-1:0] m;
        logic [ARR_W-1:0]  pass;
        assign m = mask_i[t*TERM_W +: TERM_W];
        for (genvar j = 0; j < ARR_W; j++) begin : g_lit
            // true-form select needs a 1, complement select needs a 0
            assign pass[j] = (~m[2*j] | lit_i[j]) & (~m[2*j+1] | ~lit_i[j]);
        end
        // an empty term is forced low rather than reading as all-pass
        assign term_o[t] = (|m) & (&pass);
    end

endmodule

// File: rtl/mc_sum.sv
`timescale 1ns/1ps
module mc_sum #(
    parameter int NUM_SUM = 8
) (
    input  logic [NUM_SUM-1:0] term_i,
    input  logic               invert_i,
    output logic               sum_o
);

    logic raw;

    always_comb begin
        raw = 1'b0;
        for (int k = 0; k < NUM_SUM; k++) begin
            raw = raw | term_i[k];
        end
        sum_o = raw ^ invert_i;
    end

endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
module mc_store (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic toggle_i,
    input  logic neg_edge_i,
    input  logic src_i,
    input  logic d_i,
    input  logic clr_i,
    output logic q_o
);

    typedef struct packed {
        logic bit_v;
        logic src_prev;
    } store_t;

    store_t st_d, st_q;
    logic   evt;

    always_comb begin
        st_d = st_q;
        evt  = neg_edge_i ? (st_q.src_prev & ~src_i) : (~st_q.src_prev & src_i);
        st_d.src_prev = src_i;
        if (clr_i) begin
            st_d.bit_v = 1'b0;
        end else if (evt) begin
            st_d.bit_v = toggle_i ? (st_q.bit_v ^ d_i) : d_i;
        end
        if (!rst_ni) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign q_o = st_q.bit_v;

    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !q_o); // R10

    AST_QUIET_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && (src_i == st_q.src_prev)) |=> $stable(q_o)); // R8

    AST_D_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !toggle_i && evt) |=> (q_o == $past(d_i))); // R9

endmodule

// File: rtl/pld_macrocell.sv
`timescale 1ns/1ps
module pld_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_SUM = 8,
    localparam int ARR_W  = NUM_IN + 1,
    localparam int NT     = NUM_SUM + 2,
    localparam int MASK_W = NT * 2 * ARR_W,
    localparam int CFG_W  = MASK_W + MODE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [NUM_IN-1:0] in_i,
    input  logic              gclk_i,
    input  logic              pin_i,
    output logic              pin_o,
    output logic              pin_oe_o,
    output logic              fb_o
);

    localparam int AUX_T = NUM_SUM;
    localparam int CLR_T = NUM_SUM + 1;

    typedef struct packed {
        mc_mode_t          mode;
        logic [MASK_W-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_ni) begin
            cfg_d = cfg_t'(cfg_i);
        end
    end

    always_ff @(posedge clk_i) begin
        cfg_q <= cfg_d;
    end

    logic [NT-1:0]    term;
    logic [ARR_W-1:0] lit;
    logic             sum_pol;
    logic             q;
    logic             fb;
    logic             src;

    assign fb  = cfg_q.mode.fb_pin ? pin_i : q;
    assign lit = {fb, in_i};
    assign src = cfg_q.mode.async_clk ? term[AUX_T] : gclk_i;

    mc_and_array #(
        .ARR_W     (ARR_W),
        .NUM_TERMS (NT)
    ) u_array (
        .mask_i (cfg_q.mask),
        .lit_i  (lit),
        .term_o (term)
    );

    mc_sum #(
        .NUM_SUM (NUM_SUM)
    ) u_sum (
        .term_i   (term[NUM_SUM-1:0]),
        .invert_i (cfg_q.mode.invert),
        .sum_o    (sum_pol)
    );

    mc_store u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .toggle_i   (cfg_q.mode.toggle),
        .neg_edge_i (cfg_q.mode.neg_edge),
        .src_i      (src),
        .d_i        (sum_pol),
        .clr_i      (term[CLR_T]),
        .q_o        (q)
    );

    assign pin_o    = cfg_q.mode.out_reg ? q : sum_pol;
    assign pin_oe_o = cfg_q.mode.async_clk ? 1'b1 : term[AUX_T];
    assign fb_o     = fb;

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> $stable(cfg_q)); // R1

    AST_ASYNC_OE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_q.mode.async_clk |-> pin_oe_o); // R7

endmodule

// File: tb/pld_macrocell_test.sv
`timescale 1ns/1ps
module pld_macrocell_test;

    localparam int NI    = 4;
    localparam int NS    = 8;
    localparam int AW    = NI + 1;
    localparam int TW    = 2 * AW;
    localparam int NT    = NS + 2;
    localparam int AUX   = NS;
    localparam int CLRT  = NS + 1;
    localparam int MB    = NT * TW;
    localparam int CW    = MB + 6;
    localparam int B_INV = MB;
    localparam int B_ASY = MB + 1;
    localparam int B_TOG = MB + 2;
    localparam int B_NEG = MB + 3;
    localparam int B_REG = MB + 4;
    localparam int B_FBP = MB + 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] cfg;
    logic [NI-1:0] in_v;
    logic          gclk;
    logic          pin_in;
    logic          pin_o, pin_oe, fb_o;
    int            checks = 0;
    int            errors = 0;

    always #2.5 clk = ~clk;

    pld_macrocell #(.NUM_IN(NI), .NUM_SUM(NS)) uut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .cfg_i    (cfg),
        .in_i     (in_v),
        .gclk_i   (gclk),
        .pin_i    (pin_in),
        .pin_o    (pin_o),
        .pin_oe_o (pin_oe),
        .fb_o     (fb_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] lit(input logic [CW-1:0] c, input int t,
                                          input int j, input int neg);
        c[t*TW + 2*j + neg] = 1'b1;
        return c;
    endfunction

    task automatic start(input logic [CW-1:0] c);
        rst_n = 1'b0; cfg = c; in_v = '0; gclk = 1'b0; pin_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse();
        gclk = 1'b1; @(negedge clk);
        gclk = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        logic [CW-1:0] c = '0;
        c = lit(c, 0, 0, 0); c[B_REG] = 1'b1;
        start(c);
        in_v = 4'b0001; @(negedge clk);
        chk("R1 stored bit zero after reset", pin_o, 1'b0);
        chk("R1 feedback zero after reset", fb_o, 1'b0);
    endtask

    task automatic t_comb(input bit inv);
        logic [CW-1:0] c = '0;
        c = lit(c, 0, 0, 0); c = lit(c, 0, 1, 1);
        c = lit(c, 1, 2, 0); c = lit(c, 1, 3, 0);
        c[B_INV] = inv;
        start(c);
        for (int v = 0; v < 16; v++) begin
            in_v = v[3:0]; #1;
            chk(inv ? "R4 inverted sum" : "R2 R3 AND-OR sum", pin_o,
                ((v[0] & ~v[1]) | (v[2] & v[3])) ^ inv);
        end
        // R1: changing cfg after reset must not take effect
        cfg = '1; in_v = 4'b0001; repeat (2) @(negedge clk);
        chk("R1 config frozen (high)", pin_o, 1'b1 ^ inv);
        in_v = 4'b0000; #1;
        chk("R1 config frozen (low)", pin_o, 1'b0 ^ inv);
    endtask

    task automatic t_empty();
        start('0);
        for (int v = 0; v < 16; v++) begin
            in_v = v[3:0]; #1;
            chk("R3 empty terms give 0", pin_o, 1'b0);
        end
    endtask

    task automatic t_sync_d();
        logic [CW-1:0] c = '0;
        c = lit(c, 0, 0, 0); c = lit(c, AUX, 1, 0); c[B_REG] = 1'b1;
        start(c);
        in_v = 4'b0001; @(negedge clk);
        chk("R5 registered path ignores sum without edge", pin_o, 1'b0);
        gclk = 1'b1; @(negedge clk);
        chk("R6 rising global edge captures 1", pin_o, 1'b1);
        in_v = 4'b0000; @(negedge clk);
        chk("R8 no edge holds value", pin_o, 1'b1);
        gclk = 1'b0; @(negedge clk);
        chk("R8 falling edge inactive", pin_o, 1'b1);
        gclk = 1'b1; @(negedge clk);
        chk("R6 rising edge captures 0", pin_o, 1'b0);
        in_v = 4'b0010; #1;
        chk("R6 OE follows aux term high", pin_oe, 1'b1);
        in_v = 4'b0000; #1;
        chk("R6 OE follows aux term low", pin_oe, 1'b0);
    endtask

    task automatic t_neg_edge();
        logic [CW-1:0] c = '0;
        c = lit(c, 0, 0, 0); c[B_REG] = 1'b1; c[B_NEG] = 1'b1;
        start(c);
        in_v = 4'b0001;
        gclk = 1'b1; @(negedge clk);
        chk("R8 rising ignored in falling mode", pin_o, 1'b0);
        gclk = 1'b0; @(negedge clk);
        chk("R8 falling edge captures", pin_o, 1'b1);
    endtask

    task automatic t_toggle();
        logic [CW-1:0] c = '0;
        c = lit(c, 0, 0, 0); c[B_REG] = 1'b1; c[B_TOG] = 1'b1;
        start(c);
        in_v = 4'b0001;
        pulse(); chk("R9 toggle to 1", pin_o, 1'b1);
        pulse(); chk("R9 toggle to 0", pin_o, 1'b0);
        pulse(); chk("R9 toggle to 1 again", pin_o, 1'b1);
        in_v = 4'b0000;
        pulse(); chk("R9 toggle holds when sum 0", pin_o, 1'b1);
    endtask

    task automatic t_async();
        logic [CW-1:0] c = '0;
        c = lit(c, 0, 0, 0); c = lit(c, AUX, 3, 0);
        c[B_REG] = 1'b1; c[B_ASY] = 1'b1;
        start(c);
        in_v = 4'b0001;
        pulse();
        chk("R7 global clock ignored", pin_o, 1'b0);
        chk("R7 OE held active", pin_oe, 1'b1);
        in_v = 4'b1001; @(negedge clk);
        chk("R7 aux term edge captures", pin_o, 1'b1);
        in_v = 4'b0000; @(negedge clk);
        chk("R7 aux falling edge inactive", pin_o, 1'b1);
        in_v = 4'b1000; @(negedge clk);
        chk("R7 aux edge captures 0", pin_o, 1'b0);
        chk("R7 OE stays active", pin_oe, 1'b1);
    endtask

    task automatic t_clear();
        logic [CW-1:0] c = '0;
        c = lit(c, 0, 0, 0); c = lit(c, CLRT, 1, 0); c[B_REG] = 1'b1;
        start(c);
        in_v = 4'b0001; pulse();
        chk("R10 set before clear", pin_o, 1'b1);
        in_v = 4'b0011; @(negedge clk);
        chk("R10 clear without clock edge", pin_o, 1'b0);
        pulse();
        chk("R10 clear overrides edge", pin_o, 1'b0);
        in_v = 4'b0001; @(negedge clk);
        chk("R10 released clear holds 0", pin_o, 1'b0);
        pulse();
        chk("R10 capture after release", pin_o, 1'b1);
    endtask

    task automatic t_feedback();
        logic [CW-1:0] c = '0;
        c = lit(c, 0, NI, 0); c = lit(c, 1, 0, 0);
        start(c);
        chk("R11 feedback reg starts 0", fb_o, 1'b0);
        in_v = 4'b0001; pulse();
        in_v = 4'b0000; #1;
        chk("R11 feedback shows stored bit", fb_o, 1'b1);
        chk("R11 stored bit reaches array", pin_o, 1'b1);
        c = '0; c = lit(c, 0, NI, 0); c[B_FBP] = 1'b1;
        start(c);
        pin_in = 1'b1; #1;
        chk("R11 pad feedback high", fb_o, 1'b1);
        chk("R11 pad value reaches array", pin_o, 1'b1);
        pin_in = 1'b0; #1;
        chk("R11 pad feedback low", pin_o, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_comb(1'b0);
        t_comb(1'b1);
        t_empty();
        t_sync_d();
        t_neg_edge();
        t_toggle();
        t_async();
        t_clear();
        t_feedback();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule